// File: doc/BRIEF.md
# Programmable Match Timer

This block is an up-counter with a compare register, driven from a slow timer clock and controlled through a small bank of registers. Software loads a compare value, picks a prescale and turns the counter on. Each time the count becomes equal to the compare value, the block raises a one-cycle interrupt pulse. An optional auto-restart mode returns the count to zero on the step after the compare value, which gives a periodic tick.

The block runs entirely on the bus clock. The slow timer clock comes in as a level signal. It is synchronized and edge-detected into a one-cycle step enable. A write to the clear register does not act at once. It waits for the next timer-clock edge, and until then a pending flag reads as 1. Software should poll that flag before it turns the counter back on. Reads return data on the cycle after the request.

Top module: `mtmr_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Word offsets (byte address bits [1:0] are ignored): 0x00 is the compare register (read/write, CNT_W bits, upper bits read 0). 0x04 is the count (read-only). 0x08 is the control register, bits [1:0], with bit 0 = run and bit 1 = auto-restart. 0x0C is the clear/status register. 0x10 is the prescale field, bits [DIV_W-1:0]. Reads of any other offset return 0. Read data appears on `bus_rdata` the cycle after the read request.
- R3: While run is 1, the count advances by one every N rising edges of `tmr_clk`, where N = prescale field + 1. The field values 0, 1, 2 and 3 give divide-by 1, 2, 3 and 4.
- R4: While run is 0, the count holds its value, whatever `tmr_clk` does.
- R5: A write of any data to 0x0C returns the count and the prescale phase to zero at the next rising edge of `tmr_clk`.
- R6: Bit 10 of a read at 0x0C is 1 from the write to 0x0C until the clear has taken effect, then 0. All other bits of that read are 0. Clearing run while a clear is pending does not cancel the clear.
- R7: When the count becomes equal to the compare value while run is 1, `irq` is high for exactly one bus-clock cycle. It does not pulse again while the count stays at that value.
- R8: With auto-restart set, a step taken from the compare value goes to 0 instead of compare+1, so the interrupt repeats once per compare+1 steps.
- R9: The count wraps from its all-ones value (2^CNT_W - 1) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tmr_clk | input | 1 | Slow timer clock, sampled as a level |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | One-cycle interrupt pulse on a compare hit |

## Verification
A wrong prescale phase or step condition shows at the count register within one timer period, because the count is read after a known number of timer edges counted from an aligned clear. A clear flag that is stuck or lost shows at bit 10 of the status read either at once or one timer edge later, and the count after that edge shows whether the clear landed. Duplicate or missing interrupts, or a failed auto-restart, show within a few timer edges of the compare hit, through the number of `irq` pulses and the count read back after the hit.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned PEND_BIT = 10;

    // word indices of the register bank
    localparam int unsigned W_MATCH = 0;
    localparam int unsigned W_COUNT = 1;
    localparam int unsigned W_CTRL  = 2;
    localparam int unsigned W_CLEAR = 3;
    localparam int unsigned W_DIV   = 4;

    typedef struct packed {
        logic auto_clr;   // bit 1
        logic run;        // bit 0
    } ctrl_t;

    typedef struct packed {
        logic match;
        logic ctrl;
        logic clear;
        logic div;
    } wr_stb_t;

    function automatic logic [DATA_W-1:0] pend_word(input logic p);
        return p ? (DATA_W'(1) << PEND_BIT) : '0;
    endfunction

endpackage

// File: rtl/mtmr_tick_sync.sv
module mtmr_tick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tmr_clk,
    output logic tick
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], tmr_clk};
    end

    // rising edge of the synchronized timer clock
    assign tick = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              pend,
    output logic [CNT_W-1:0]  match_q,
    output ctrl_t             ctrl_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              clr_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    wr_stb_t          stb;
    logic [DATA_W-1:0] rd_mux;
    logic             unused_bits;

    assign widx        = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_wdata, bus_addr[1:0]};

    always_comb begin
        stb       = '0;
        stb.match = bus_sel && bus_wr && (widx == IDX_W'(W_MATCH));
        stb.ctrl  = bus_sel && bus_wr && (widx == IDX_W'(W_CTRL));
        stb.clear = bus_sel && bus_wr && (widx == IDX_W'(W_CLEAR));
        stb.div   = bus_sel && bus_wr && (widx == IDX_W'(W_DIV));
    end

    assign clr_wr = stb.clear;

    always_comb begin
        rd_mux = '0;
        if (widx == IDX_W'(W_MATCH)) rd_mux = DATA_W'(match_q);
        if (widx == IDX_W'(W_COUNT)) rd_mux = DATA_W'(cnt);
        if (widx == IDX_W'(W_CTRL))  rd_mux = DATA_W'(ctrl_q);
        if (widx == IDX_W'(W_CLEAR)) rd_mux = pend_word(pend);
        if (widx == IDX_W'(W_DIV))   rd_mux = DATA_W'(div_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q   <= '0;
            ctrl_q    <= '0;
            div_q     <= '0;
            bus_rdata <= '0;
        end else begin
            if (stb.match) match_q <= bus_wdata[CNT_W-1:0];
            if (stb.ctrl)  ctrl_q  <= bus_wdata[1:0];
            if (stb.div)   div_q   <= bus_wdata[DIV_W-1:0];
            if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/mtmr_core.sv
module mtmr_core
    import mtmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] match,
    input  logic [DIV_W-1:0] div,
    input  logic             clr_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             pend,
    output logic             irq
);
    logic [DIV_W-1:0] presc;
    logic             adv;
    logic             eq_now;
    logic             eq_q;

    assign adv    = tick && (presc >= div);
    assign eq_now = ctrl.run && (cnt == match);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            presc <= '0;
            pend  <= 1'b0;
            eq_q  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            if (clr_wr)    pend <= 1'b1;
            else if (tick) pend <= 1'b0;

            if (tick && pend) begin
                cnt   <= '0;
                presc <= '0;
            end else if (tick && ctrl.run) begin
                presc <= adv ? '0 : presc + DIV_W'(1);
                if (adv) begin
                    if (ctrl.auto_clr && (cnt == match)) cnt <= '0;
                    else                                 cnt <= cnt + CNT_W'(1);
                end
            end

            eq_q <= eq_now;
            irq  <= eq_now & ~eq_q;
        end
    end
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DIV_W       = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic [CNT_W-1:0] match_q;
    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             clr_wr;

    mtmr_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .tmr_clk (tmr_clk),
        .tick    (tick)
    );

    mtmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .pend      (pend),
        .match_q   (match_q),
        .ctrl_q    (ctrl_q),
        .div_q     (div_q),
        .clr_wr    (clr_wr),
        .bus_rdata (bus_rdata)
    );

    mtmr_core #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .ctrl   (ctrl_q),
        .match  (match_q),
        .div    (div_q),
        .clr_wr (clr_wr),
        .cnt    (cnt),
        .pend   (pend),
        .irq    (irq)
    );
endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             run,
    input logic             pend,
    input logic             clr_wr,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] match
);
    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (!run && !pend) |=> $stable(cnt));

    p_clear_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && pend) |=> (cnt == '0));

    p_pend_set_r6: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> pend);

    p_pend_drop_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> $past(tick));

    p_irq_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_at_match_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(run && (cnt == match)));

    p_step_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> ((cnt == '0) || (cnt == CNT_W'($past(cnt) + CNT_W'(1)))));
endmodule

bind mtmr_top mtmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .run    (ctrl_q.run),
    .pend   (pend),
    .clr_wr (clr_wr),
    .irq    (irq),
    .cnt    (cnt),
    .match  (match_q)
);

// File: tb/mtmr_top_bench.sv
module mtmr_top_bench;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_clk = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 0;

    always #10 clk = ~clk;                       // 50 MHz
    initial begin #5; forever #120 tmr_clk = ~tmr_clk; end

    always @(negedge clk) if (irq) pulses = pulses + 1;

    mtmr_top #(.CNT_W(CW)) u_mtmr_top (
        .clk(clk), .rst(rst), .tmr_clk(tmr_clk),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk); bus_sel = 0; d = bus_rdata;
    endtask

    task automatic wait_ticks(input int k);
        repeat (k) @(posedge tmr_clk);
        repeat (5) @(negedge clk);
    endtask

    // stop, clear, check pending flag, then start with the given control
    task automatic restart(input logic [31:0] ctl);
        logic [31:0] d;
        wait_ticks(1);
        bus_write(5'h08, 32'h0);
        bus_write(5'h0C, 32'hDEAD_BEEF);
        bus_read(5'h0C, d);  chk("R6 pending after clear write", d, 32'h0000_0400);
        wait_ticks(1);
        bus_read(5'h0C, d);  chk("R6 pending dropped", d, 32'h0);
        bus_read(5'h04, d);  chk("R5 count cleared", d, 32'h0);
        bus_write(5'h08, ctl);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq low", {31'b0, irq}, 32'h0);
        bus_read(5'h00, d); chk("R1 compare reset", d, 0);
        bus_read(5'h04, d); chk("R1 count reset", d, 0);
        bus_read(5'h08, d); chk("R1 control reset", d, 0);
        bus_read(5'h0C, d); chk("R1 status reset", d, 0);
        bus_read(5'h10, d); chk("R1 prescale reset", d, 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        bus_write(5'h00, 32'h1234_56A5);
        bus_read(5'h00, d); chk("R2 compare width", d, 32'h0000_00A5);
        bus_write(5'h08, 32'hFFFF_FFFE);
        bus_read(5'h08, d); chk("R2 control bits", d, 32'h2);
        bus_write(5'h10, 32'hFFFF_FFF7);
        bus_read(5'h10, d); chk("R2 prescale bits", d, 32'h3);
        bus_read(5'h14, d); chk("R2 unmapped 0x14", d, 0);
        bus_read(5'h1C, d); chk("R2 unmapped 0x1C", d, 0);
        bus_write(5'h04, 32'h55);
        bus_read(5'h04, d); chk("R2 count read-only", d, 0);
        bus_write(5'h00, 32'h0);
        bus_write(5'h08, 32'h0);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        for (int dv = 0; dv < 4; dv++) begin
            bus_write(5'h10, dv);
            restart(32'h1);
            wait_ticks(8);
            bus_read(5'h04, d);
            chk($sformatf("R3 count after 8 edges, div field %0d", dv), d, 8 / (dv + 1));
        end
        bus_write(5'h10, 0);
    endtask

    task automatic t_freeze;
        logic [31:0] d;
        restart(32'h1);
        wait_ticks(3);
        bus_read(5'h04, d); chk("R3 three steps", d, 3);
        bus_write(5'h08, 32'h0);
        wait_ticks(3);
        bus_read(5'h04, d); chk("R4 count frozen", d, 3);
    endtask

    task automatic t_pending_survives;
        logic [31:0] d;
        restart(32'h1);
        wait_ticks(2);
        bus_write(5'h0C, 32'h0);
        bus_write(5'h08, 32'h0);
        bus_read(5'h0C, d); chk("R6 pending kept after stop", d, 32'h0000_0400);
        wait_ticks(1);
        bus_read(5'h0C, d); chk("R6 pending completes", d, 0);
        bus_read(5'h04, d); chk("R5 clear applied while stopped", d, 0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        int base;
        bus_write(5'h00, 2);
        bus_write(5'h10, 3);
        restart(32'h1);
        base = pulses;
        wait_ticks(7);
        bus_read(5'h04, d); chk("R3 div4 count", d, 1);
        chk("R7 no pulse before hit", pulses - base, 0);
        wait_ticks(1);
        bus_read(5'h04, d); chk("R7 count at compare", d, 2);
        chk("R7 one pulse at hit", pulses - base, 1);
        wait_ticks(3);
        chk("R7 no repeat while held", pulses - base, 1);
        wait_ticks(1);
        bus_read(5'h04, d); chk("R7 count past compare", d, 3);
        bus_write(5'h10, 0);
    endtask

    task automatic t_autoclr;
        logic [31:0] d;
        int base;
        bus_write(5'h00, 3);
        restart(32'h3);
        base = pulses;
        wait_ticks(3);
        bus_read(5'h04, d); chk("R8 reach compare", d, 3);
        chk("R8 first pulse", pulses - base, 1);
        wait_ticks(1);
        bus_read(5'h04, d); chk("R8 restart to zero", d, 0);
        wait_ticks(3);
        bus_read(5'h04, d); chk("R8 second period", d, 3);
        chk("R8 second pulse", pulses - base, 2);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        bus_write(5'h00, 32'h0);
        restart(32'h1);
        wait_ticks(255);
        bus_read(5'h04, d); chk("R9 all ones", d, 32'hFF);
        wait_ticks(1);
        bus_read(5'h04, d); chk("R9 wrapped", d, 0);
        wait_ticks(1);
        bus_read(5'h04, d); chk("R9 after wrap", d, 1);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_prescale;
        t_freeze;
        t_pending_survives;
        t_irq;
        t_autoclr;
        t_wrap;
        done = 1;
        summary;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            summary;
        end
    end
endmodule